// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block is the receive-side character store of a 16550-style serial port. The deserializer hands it a received byte with a one-cycle strobe, or a line-break event, and the host pops bytes through a read strobe. With queuing switched on, up to sixteen bytes are held in arrival order. With queuing switched off, a single holding register stands in for the queue. A byte that arrives into a full queue is thrown away and flagged. A break event stores a zero byte.

The host programs the queue through an 8-bit queue-control write. That write turns queuing on or off, empties the receive store, requests a flush of the transmit store, and selects the trigger level that the interrupt logic compares against the fill count. The block also runs an idle timer. The timer counts bit periods, taken from a bit-period tick and from the line format (word length, parity and stop bits). It raises a flag when bytes have sat unread for four whole character times.

Top module: `rx_char_queue`

## Requirements
- R1: In queuing mode the store holds up to 16 bytes and returns them in arrival order. `fifo_count` gives the number held and `data_ready` is high whenever it is non-zero.
- R2: Queue-control bits 7:6 set the trigger level: code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `trig_reached` is high while the fill count is at or above that level.
- R3: A byte or break that arrives while 16 bytes are held, with no pop in the same cycle, is discarded. The held bytes are unchanged and `overrun` is set.
- R4: A break event stores the byte 0x00 and sets both `brk_flag` and `data_ready`.
- R5: `timeout_flag` rises after four character times, counted in `bit_tick` pulses, during which the store is non-empty and sees no push and no pop. Any push or pop restarts the count.
- R6: A pop clears `timeout_flag`. A pop that leaves the store empty also clears `data_ready` and `brk_flag`.
- R7: A line-status read (`lsr_rd`) clears `brk_flag` and `overrun`.
- R8: On a queue-control write, `fcr_state` keeps only the bits under mask 0xC9. Bit 1, or a change of bit 0, empties the receive store. Bit 2, or a change of bit 0, pulses `tx_flush` for one cycle after the write.
- R9: With queuing off (bit 0 clear), a single register holds the last byte. A byte that arrives while `data_ready` is set, with no pop in that cycle, replaces the held byte and sets `overrun`.
- R10: One character time is 1 start bit, plus 5 + `lcr_wlen` data bits, plus 1 bit if `lcr_parity_en` is set, plus 2 stop bits if `lcr_stop2` is set and 1 stop bit otherwise.
- R11: Emptying the receive store also clears the timeout count and `timeout_flag`.
- R12: A pop from an empty store in queuing mode shows 0x00 on `rd_data` and changes no state. The next byte pushed is the next byte popped.
- R13: After reset the store is empty, queuing is off, `fcr_state` is 0x00, the trigger level is 1 and all status flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break event strobe (stores 0x00) |
| bit_tick | input | 1 | One pulse per serial bit period |
| lcr_wlen | input | 2 | Data bits minus 5 |
| lcr_parity_en | input | 1 | Parity bit present in frame |
| lcr_stop2 | input | 1 | Two stop bits |
| fcr_we | input | 1 | Queue-control write strobe |
| fcr_wdata | input | 8 | Queue-control write value |
| rd_pop | input | 1 | Host data read (pops one byte) |
| lsr_rd | input | 1 | Host line-status read |
| rd_data | output | 8 | Byte at the head of the store, or the holding register |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A byte was lost |
| brk_flag | output | 1 | Break received |
| timeout_flag | output | 1 | Data left unread for four character times |
| fifo_en | output | 1 | Queuing mode active |
| fcr_state | output | 8 | Retained queue-control bits |
| trig_level | output | 5 | Trigger level in bytes |
| trig_reached | output | 1 | Fill count at or above the trigger level |
| fifo_count | output | 5 | Bytes held |
| tx_flush | output | 1 | One-cycle request to empty the transmit store |

## Verification
The bound checker checks several relations on every cycle. The fill count never exceeds the depth. A discarded byte leaves a full store with `overrun` set. The break and timeout flags are never set over an empty store. A pop or a receive flush always drops the timeout flag, a line-status read with no arrival clears both error flags, and the retained control bits follow the mask. Some behaviour only the bench's scenarios can show: arrival order of the bytes, the exact bit-tick count at which the timeout fires for two different line formats, the restart of that count by a push, the mapping of trigger codes to levels, and the overwrite of the holding register in non-queuing mode.

// File: rtl/rcq_pkg.sv
package rcq_pkg;

  // bits of the queue-control byte that are retained
  localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;
  // width of the idle-timer counter: 4 * 12 bits max = 48
  localparam int TMO_W = 6;

  // bits per character: start + data + optional parity + stop
  function automatic logic [3:0] frame_bits(input logic [1:0] wlen,
                                            input logic parity_en,
                                            input logic stop2);
    logic [3:0] n;
    n = 4'd1 + 4'd5 + {2'b00, wlen};
    n = n + {3'b000, parity_en};
    n = n + (stop2 ? 4'd2 : 4'd1);
    return n;
  endfunction

  // trigger level in bytes for a 2-bit code, clamped to the depth
  function automatic int trig_bytes(input logic [1:0] code, input int depth);
    int lvl;
    case (code)
      2'b00:   lvl = 1;
      2'b01:   lvl = 4;
      2'b10:   lvl = 8;
      default: lvl = 14;
    endcase
    return (lvl > depth) ? depth : lvl;
  endfunction

endpackage

// File: rtl/rcq_ring.sv
module rcq_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  assign rdata = (cnt_q == '0) ? '0 : mem[rd_ptr];
  assign count = cnt_q;

endmodule

// File: rtl/rcq_timer.sv
module rcq_timer #(
  parameter int TW = rcq_pkg::TMO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          flag_clr,
  input  logic          active,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          fire,
  output logic          flag
);
  logic [TW-1:0] cnt_q;
  logic          flag_q;
  logic          step;

  assign step = active && tick && !restart && !flag_q;
  assign fire = step && (cnt_q == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || fire) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (flag_clr) flag_q <= 1'b0;
    else if (fire)     flag_q <= 1'b1;
  end

  assign flag = flag_q;

endmodule

// File: rtl/rcq_fcr.sv
module rcq_fcr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic       flush_rx,
  output logic       flush_tx,
  output logic       en,
  output logic [1:0] lvl_code,
  output logic [7:0] state
);
  logic [7:0] fcr_q;
  logic       en_change;

  assign en_change = wdata[0] ^ fcr_q[0];
  assign flush_rx  = we && (wdata[1] || en_change);
  assign flush_tx  = we && (wdata[2] || en_change);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  fcr_q <= 8'h00;
    else if (we) fcr_q <= wdata & rcq_pkg::FCR_KEEP_MASK;
  end

  assign en       = fcr_q[0];
  assign lvl_code = fcr_q[7:6];
  assign state    = fcr_q;

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_break,
  input  logic          bit_tick,
  input  logic [1:0]    lcr_wlen,
  input  logic          lcr_parity_en,
  input  logic          lcr_stop2,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic          rd_pop,
  input  logic          lsr_rd,
  output logic [7:0]    rd_data,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_flag,
  output logic          timeout_flag,
  output logic          fifo_en,
  output logic [7:0]    fcr_state,
  output logic [CW-1:0] trig_level,
  output logic          trig_reached,
  output logic [CW-1:0] fifo_count,
  output logic          tx_flush
);
  import rcq_pkg::*;

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // named internal events (observed by the checker)
  logic       rx_flush, tx_flush_now;
  logic       any_rx;
  logic [7:0] rx_byte;
  logic       full;
  logic       push_ok, pop_ok, drop_evt;
  logic       hold_wr, hold_rd, hold_ovr;
  logic       empties;
  logic       tmo_fire;
  logic [1:0] lvl_code;
  logic [7:0] ring_rdata;
  logic [TMO_W-1:0] tmo_limit;

  logic [7:0] hold_q;
  logic       hold_dr_q, oe_q, bi_q, tx_flush_q;

  rcq_fcr u_fcr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (fcr_we),
    .wdata    (fcr_wdata),
    .flush_rx (rx_flush),
    .flush_tx (tx_flush_now),
    .en       (fifo_en),
    .lvl_code (lvl_code),
    .state    (fcr_state)
  );

  assign any_rx  = rx_valid || rx_break;
  assign rx_byte = rx_break ? 8'h00 : rx_data;
  assign full    = (fifo_count == FULL);

  // queuing-mode events
  assign pop_ok   = fifo_en && rd_pop && (fifo_count != '0) && !rx_flush;
  assign push_ok  = fifo_en && any_rx && !rx_flush && (!full || pop_ok);
  assign drop_evt = fifo_en && any_rx && !rx_flush && full && !pop_ok;
  assign empties  = pop_ok && !push_ok && (fifo_count == CW'(1));

  // holding-register events
  assign hold_wr  = !fifo_en && any_rx && !rx_flush;
  assign hold_rd  = !fifo_en && rd_pop && !rx_flush;
  assign hold_ovr = hold_wr && hold_dr_q && !rd_pop;

  rcq_ring #(.DEPTH(DEPTH), .W(8), .CW(CW)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (rx_byte),
    .rdata (ring_rdata),
    .count (fifo_count)
  );

  assign tmo_limit = {frame_bits(lcr_wlen, lcr_parity_en, lcr_stop2), 2'b00};

  rcq_timer #(.TW(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (push_ok || pop_ok || rx_flush),
    .flag_clr (pop_ok || rx_flush),
    .active   (fifo_en && (fifo_count != '0)),
    .tick     (bit_tick),
    .limit    (tmo_limit),
    .fire     (tmo_fire),
    .flag     (timeout_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 8'h00;
      hold_dr_q <= 1'b0;
    end else if (rx_flush) begin
      hold_dr_q <= 1'b0;
    end else if (hold_wr) begin
      hold_q    <= rx_byte;
      hold_dr_q <= 1'b1;
    end else if (hold_rd) begin
      hold_dr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     oe_q <= 1'b0;
    else if (drop_evt || hold_ovr)  oe_q <= 1'b1;
    else if (lsr_rd)                oe_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             bi_q <= 1'b0;
    else if (rx_flush)                      bi_q <= 1'b0;
    else if (rx_break)                      bi_q <= 1'b1;
    else if (lsr_rd || empties || hold_rd)  bi_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_flush_q <= 1'b0;
    else        tx_flush_q <= tx_flush_now;
  end

  assign rd_data      = fifo_en ? ring_rdata : hold_q;
  assign data_ready   = fifo_en ? (fifo_count != '0) : hold_dr_q;
  assign overrun      = oe_q;
  assign brk_flag     = bi_q;
  assign tx_flush     = tx_flush_q;
  assign trig_level   = CW'(trig_bytes(lvl_code, DEPTH));
  assign trig_reached = fifo_en ? (fifo_count >= trig_level) : hold_dr_q;

endmodule

// File: rtl/rcq_checker.sv
module rcq_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rd_pop,
  input logic          lsr_rd,
  input logic          fcr_we,
  input logic [7:0]    fcr_wdata,
  input logic          fifo_en,
  input logic [CW-1:0] fifo_count,
  input logic          data_ready,
  input logic          overrun,
  input logic          brk_flag,
  input logic          timeout_flag,
  input logic [7:0]    fcr_state,
  input logic          drop_evt,
  input logic          pop_ok,
  input logic          rx_flush
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH)); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (overrun && fifo_count == CW'(DEPTH))); // R3
  AST_BRK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |-> data_ready); // R4
  AST_TMO_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> (fifo_count != '0)); // R5
  AST_POP_CLR_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> !timeout_flag); // R6
  AST_LSR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rx_break) |=> (!brk_flag && !overrun)); // R7
  AST_FCR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we |=> (fcr_state == ($past(fcr_wdata) & 8'hC9))); // R8
  AST_HOLD_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_valid && data_ready && !rd_pop && !fcr_we) |=> overrun); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (fifo_count == '0 && !timeout_flag)); // R11
  AST_EMPTY_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rd_pop && fifo_count == '0 && !rx_valid && !rx_break && !fcr_we)
      |=> (fifo_count == '0)); // R12
endmodule

bind rx_char_queue rcq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_break     (rx_break),
  .rd_pop       (rd_pop),
  .lsr_rd       (lsr_rd),
  .fcr_we       (fcr_we),
  .fcr_wdata    (fcr_wdata),
  .fifo_en      (fifo_en),
  .fifo_count   (fifo_count),
  .data_ready   (data_ready),
  .overrun      (overrun),
  .brk_flag     (brk_flag),
  .timeout_flag (timeout_flag),
  .fcr_state    (fcr_state),
  .drop_evt     (drop_evt),
  .pop_ok       (pop_ok),
  .rx_flush     (rx_flush)
);

// File: tb/rx_char_queue_tb_top.sv
module rx_char_queue_tb_top;
  localparam int OP_FCR  = 0;
  localparam int OP_PUSH = 1;
  localparam int OP_BRK  = 2;
  localparam int OP_POP  = 3;
  localparam int OP_LSR  = 4;

  // {op[2:0], data[7:0], exp_rd[7:0], exp_cnt[4:0], flags{dr,oe,bi,tmo}}
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 8'h47, 8'h00, 5'd0, 4'b0000},
    {3'd1, 8'h11, 8'h00, 5'd1, 4'b1000},
    {3'd1, 8'h22, 8'h00, 5'd2, 4'b1000},
    {3'd2, 8'h00, 8'h00, 5'd3, 4'b1010},
    {3'd3, 8'h00, 8'h11, 5'd2, 4'b1010},
    {3'd3, 8'h00, 8'h22, 5'd1, 4'b1010},
    {3'd3, 8'h00, 8'h00, 5'd0, 4'b0000},
    {3'd3, 8'h00, 8'h00, 5'd0, 4'b0000},
    {3'd1, 8'h5A, 8'h00, 5'd1, 4'b1000},
    {3'd4, 8'h00, 8'h00, 5'd1, 4'b1000},
    {3'd3, 8'h00, 8'h5A, 5'd0, 4'b0000},
    {3'd2, 8'h00, 8'h00, 5'd1, 4'b1010},
    {3'd4, 8'h00, 8'h00, 5'd1, 4'b1000},
    {3'd3, 8'h00, 8'h00, 5'd0, 4'b0000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_break = 1'b0, bit_tick = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [1:0] lcr_wlen = 2'd3;
  logic       lcr_parity_en = 1'b0, lcr_stop2 = 1'b0;
  logic       fcr_we = 1'b0;
  logic [7:0] fcr_wdata = 8'h00;
  logic       rd_pop = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data, fcr_state;
  logic       data_ready, overrun, brk_flag, timeout_flag, fifo_en;
  logic       trig_reached, tx_flush;
  logic [4:0] trig_level, fifo_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_char_queue dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .bit_tick(bit_tick), .lcr_wlen(lcr_wlen),
    .lcr_parity_en(lcr_parity_en), .lcr_stop2(lcr_stop2), .fcr_we(fcr_we),
    .fcr_wdata(fcr_wdata), .rd_pop(rd_pop), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
    .brk_flag(brk_flag), .timeout_flag(timeout_flag), .fifo_en(fifo_en),
    .fcr_state(fcr_state), .trig_level(trig_level),
    .trig_reached(trig_reached), .fifo_count(fifo_count), .tx_flush(tx_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one operation: drive for a cycle, peek head before the edge
  task automatic do_op(input int op, input logic [7:0] d, output logic [7:0] peek);
    @(negedge clk);
    peek = rd_data;
    case (op)
      OP_FCR:  begin fcr_we = 1'b1; fcr_wdata = d; end
      OP_PUSH: begin rx_valid = 1'b1; rx_data = d; end
      OP_BRK:  rx_break = 1'b1;
      OP_POP:  rd_pop = 1'b1;
      default: lsr_rd = 1'b1;
    endcase
    @(negedge clk);
    fcr_we = 1'b0; rx_valid = 1'b0; rx_break = 1'b0; rd_pop = 1'b0; lsr_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      OP_FCR:  return "R8";
      OP_PUSH: return "R1";
      OP_BRK:  return "R4";
      OP_POP:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] pk;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 count", fifo_count, 0);
    chk("R13 flags", {data_ready, overrun, brk_flag, timeout_flag}, 0);
    chk("R13 fcr", fcr_state, 8'h00);
    chk("R13 en", fifo_en, 0);
    chk("R13 level", trig_level, 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int op;
      op = int'(VEC[v][27:25]);
      do_op(op, VEC[v][24:17], pk);
      if (op == OP_POP) chk($sformatf("%s rd v%0d", op_tag(op), v), pk, VEC[v][16:9]);
      chk($sformatf("%s cnt v%0d", op_tag(op), v), fifo_count, VEC[v][8:4]);
      chk($sformatf("%s flags v%0d", op_tag(op), v),
          {data_ready, overrun, brk_flag, timeout_flag}, VEC[v][3:0]);
    end

    // R2 trigger codes
    do_op(OP_FCR, 8'h01, pk); chk("R2 lvl00", trig_level, 1);
    do_op(OP_FCR, 8'h41, pk); chk("R2 lvl01", trig_level, 4);
    do_op(OP_FCR, 8'hC1, pk); chk("R2 lvl11", trig_level, 14);
    do_op(OP_FCR, 8'h81, pk); chk("R2 lvl10", trig_level, 8);
    for (int i = 0; i < 7; i++) do_op(OP_PUSH, 8'(i), pk);
    chk("R2 below", trig_reached, 0);
    do_op(OP_PUSH, 8'h07, pk);
    chk("R2 reached", trig_reached, 1);

    // R8 control write handling
    do_op(OP_FCR, 8'h83, pk);
    chk("R8 rx reset cnt", fifo_count, 0);
    chk("R8 no tx flush", tx_flush, 0);
    chk("R8 mask", fcr_state, 8'h81);
    do_op(OP_FCR, 8'h85, pk);
    chk("R8 tx flush", tx_flush, 1);
    @(negedge clk);
    chk("R8 tx pulse one cycle", tx_flush, 0);
    do_op(OP_FCR, 8'hFF, pk);
    chk("R8 mask C9", fcr_state, 8'hC9);

    // R3 overrun on full store
    for (int i = 0; i < 16; i++) do_op(OP_PUSH, 8'h80 + 8'(i), pk);
    chk("R3 full", fifo_count, 16);
    chk("R3 no oe yet", overrun, 0);
    do_op(OP_PUSH, 8'hEE, pk);
    chk("R3 count kept", fifo_count, 16);
    chk("R3 oe", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      do_op(OP_POP, 8'h00, pk);
      chk("R3 R1 order", pk, 8'h80 + 8'(i));
    end
    chk("R1 empty dr", data_ready, 0);
    do_op(OP_LSR, 8'h00, pk);
    chk("R7 oe clear", overrun, 0);

    // R12 empty pop
    do_op(OP_POP, 8'h00, pk);
    chk("R12 rd zero", pk, 0);
    chk("R12 count", fifo_count, 0);
    do_op(OP_PUSH, 8'h3C, pk);
    do_op(OP_POP, 8'h00, pk);
    chk("R12 next byte", pk, 8'h3C);

    // R5 / R10 timeout, 8N1 -> 10 bits -> 40 ticks
    lcr_wlen = 2'd3; lcr_parity_en = 1'b0; lcr_stop2 = 1'b0;
    do_op(OP_PUSH, 8'hA1, pk);
    ticks(39); chk("R5 before", timeout_flag, 0);
    ticks(1);  chk("R5 fire", timeout_flag, 1);
    do_op(OP_POP, 8'h00, pk);
    chk("R6 pop clears tmo", timeout_flag, 0);
    do_op(OP_PUSH, 8'hB2, pk);
    ticks(20);
    do_op(OP_PUSH, 8'hC3, pk);
    ticks(39); chk("R5 restart before", timeout_flag, 0);
    ticks(1);  chk("R5 restart fire", timeout_flag, 1);
    // R10: 5 data, parity, 2 stop -> 9 bits -> 36 ticks
    lcr_wlen = 2'd0; lcr_parity_en = 1'b1; lcr_stop2 = 1'b1;
    do_op(OP_POP, 8'h00, pk);
    chk("R6 clear leaves data", timeout_flag, 0);
    chk("R6 count", fifo_count, 1);
    ticks(35); chk("R10 before", timeout_flag, 0);
    ticks(1);  chk("R10 fire", timeout_flag, 1);
    do_op(OP_FCR, 8'hCB, pk);
    chk("R11 flag cleared", timeout_flag, 0);
    chk("R11 count", fifo_count, 0);
    do_op(OP_PUSH, 8'hD4, pk);
    ticks(35); chk("R11 counter fresh", timeout_flag, 0);

    // R9 holding-register mode
    do_op(OP_FCR, 8'h00, pk);
    chk("R8 en change flush", fifo_count, 0);
    chk("R8 en change tx", tx_flush, 1);
    chk("R9 dr cleared", data_ready, 0);
    do_op(OP_PUSH, 8'h31, pk);
    chk("R9 dr", data_ready, 1);
    chk("R9 no oe", overrun, 0);
    do_op(OP_PUSH, 8'h32, pk);
    chk("R9 oe", overrun, 1);
    do_op(OP_POP, 8'h00, pk);
    chk("R9 newest byte", pk, 8'h32);
    chk("R9 dr after read", data_ready, 0);
    do_op(OP_BRK, 8'h00, pk);
    chk("R4 hold brk", {data_ready, brk_flag}, 2'b11);
    chk("R4 hold byte", rd_data, 0);

    finish_run();
  end
endmodule